// File: doc/BRIEF.md
# Ring Beacon Supervision Interrupt Unit

This unit watches ring beacon traffic on two ring ports and collects what it sees into a write-one-to-clear interrupt status register. An upstream frame parser gives it one strobe per port for each beacon, together with the beacon's state field, and a strobe with the source address of each frame received on port 1. For each port the unit records that a beacon arrived and whether its state field differs from the previous beacon on that port. It also runs a watchdog that flags a port when no beacon has arrived within a programmable number of clock cycles. Separately, it flags a loop when a frame on port 1 carries the host's own MAC address as its source.

Each status bit has an enable bit. The beacon events are enabled through one mask register and the loop event through a separate control register. A single registered interrupt line reports whether any enabled status bit is set. The host reaches the registers through a small bus with write strobe, address and write data. Read data is combinational on the address.

Top module: `ring_beacon_irq`

## Requirements
- R1: A strobe on `bcn_rx_i[p]` sets the beacon-received status bit of that port (bit 0 for port 1, bit 1 for port 2) at the same clock edge.
- R2: A beacon whose state field differs from the previous beacon on the same port sets that port's state-change bit (bit 2 for port 1, bit 3 for port 2). Equal state leaves the bit clear, and state seen on the other port does not count.
- R3: The first beacon on a port after reset, or after that port timed out, only records its state. It never sets the state-change bit.
- R4: When `tmo_period_i` = N > 0 and no beacon arrives on a port for N clock edges after its last beacon, that port's timeout bit is set (bit 4 for port 1, bit 5 for port 2) at the N-th edge. It is set once only, until a new beacon re-arms the watchdog.
- R5: A `tmo_period_i` of zero disables timeout detection.
- R6: A strobe on `frame_rx_i` with `frame_sa_i` equal to `host_mac_i` sets the loop status bit (bit 6). A different source address has no effect.
- R7: Writing address 0 clears each status bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R8: If a hardware event and a host clear hit the same status bit in one cycle, the bit ends up set.
- R9: Address 1 bits 5:0 enable status bits 5:0, and address 2 bit 0 enables the loop bit. `irq_o` is high one cycle after any enabled status bit is set, and low one cycle after none remains.
- R10: Reads return the status register at address 0, the beacon mask at address 1 and the control register at address 2. Address 3 reads zero, and all registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcn_rx_i | input | 2 | Beacon received strobe, one per port |
| bcn_state_i | input | 16 | Beacon state field per port, port 1 in bits 7:0 |
| frame_rx_i | input | 1 | Frame received on port 1 strobe |
| frame_sa_i | input | 48 | Source address of the port 1 frame |
| host_mac_i | input | 48 | Host MAC address |
| tmo_period_i | input | 24 | Beacon timeout in clock cycles, 0 disables it |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Host interrupt |

## Verification
The bench looks for a state-change flag on the first beacon after reset or after a timeout. A design that kept the stale state would raise a spurious change there. It also sends the same state on the other port, to catch a design that compares across ports. The timeout is sampled one edge before and at the expiry edge to catch an off-by-one count, and then watched for a long idle stretch to catch a watchdog that refires. Separate cases strike a set and a clear on the same bit in one cycle, write zero to the status register, and enable the loop bit through the control register, which catch a lost event, a plain-write status register, and a loop mask wired to the wrong register.

// File: rtl/rbi_pkg.sv
package rbi_pkg;
  localparam int NUM_PORTS = 2;
  localparam int STS_W     = 3 * NUM_PORTS + 1;
  localparam int BMASK_W   = 3 * NUM_PORTS;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;

  localparam int B_RX   = 0;
  localparam int B_CHG  = NUM_PORTS;
  localparam int B_TMO  = 2 * NUM_PORTS;
  localparam int B_LOOP = 3 * NUM_PORTS;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS   = 2'd0,
    RA_BCN_MASK = 2'd1,
    RA_CTRL     = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/rbi_port_mon.sv
module rbi_port_mon #(
  parameter int STATE_W = 8,
  parameter int TMO_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bcn_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [TMO_W-1:0]   period_i,
  output logic               rx_o,
  output logic               chg_o,
  output logic               tmo_o
);
  logic [STATE_W-1:0] prev_q;
  logic               have_prev_q;
  logic               armed_q;
  logic [TMO_W-1:0]   cnt_q;
  logic               tmo_en;
  logic               tmo_hit;

  assign tmo_en  = (period_i != '0);
  assign tmo_hit = !bcn_i && armed_q && tmo_en && (cnt_q >= period_i - TMO_W'(1));
  assign rx_o    = bcn_i;
  assign chg_o   = bcn_i && have_prev_q && (state_i != prev_q);
  assign tmo_o   = tmo_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      armed_q     <= 1'b1;
      cnt_q       <= '0;
    end else if (bcn_i) begin
      prev_q      <= state_i;
      have_prev_q <= 1'b1;
      armed_q     <= 1'b1;
      cnt_q       <= '0;
    end else if (tmo_hit) begin
      // timed out: forget state, stay silent until next beacon
      have_prev_q <= 1'b0;
      armed_q     <= 1'b0;
      cnt_q       <= '0;
    end else if (armed_q && tmo_en) begin
      cnt_q <= cnt_q + TMO_W'(1);
    end else if (!tmo_en) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/rbi_loop_det.sv
module rbi_loop_det #(
  parameter int MAC_W = 48
) (
  input  logic             frame_i,
  input  logic [MAC_W-1:0] sa_i,
  input  logic [MAC_W-1:0] host_mac_i,
  output logic             loop_o
);
  assign loop_o = frame_i && (sa_i == host_mac_i);
endmodule

// File: rtl/rbi_status_regs.sv
module rbi_status_regs
  import rbi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STS_W-1:0]  set_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [STS_W-1:0]  sts_o,
  output logic [STS_W-1:0]  en_o,
  output logic              irq_o
);
  logic [STS_W-1:0]   sts_q;
  logic [BMASK_W-1:0] bmask_q;
  logic               lmask_q;
  logic [STS_W-1:0]   clr;
  logic               irq_q;

  assign clr   = (we_i && addr_i == RA_STATUS) ? wdata_i[STS_W-1:0] : '0;
  assign en_o  = {lmask_q, bmask_q};
  assign sts_o = sts_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= '0;
      bmask_q <= '0;
      lmask_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_i;  // set wins over clear
      if (we_i && addr_i == RA_BCN_MASK) bmask_q <= wdata_i[BMASK_W-1:0];
      if (we_i && addr_i == RA_CTRL)     lmask_q <= wdata_i[0];
      irq_q <= |(sts_q & en_o);
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_STATUS:   rdata_o = DATA_W'(sts_q);
      RA_BCN_MASK: rdata_o = DATA_W'(bmask_q);
      RA_CTRL:     rdata_o = DATA_W'(lmask_q);
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ring_beacon_irq.sv
module ring_beacon_irq
  import rbi_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int MAC_W   = 48,
  parameter int TMO_W   = 24
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PORTS-1:0]         bcn_rx_i,
  input  logic [NUM_PORTS*STATE_W-1:0] bcn_state_i,
  input  logic                         frame_rx_i,
  input  logic [MAC_W-1:0]             frame_sa_i,
  input  logic [MAC_W-1:0]             host_mac_i,
  input  logic [TMO_W-1:0]             tmo_period_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic                         irq_o
);
  logic [NUM_PORTS-1:0] rx_ev, chg_ev, tmo_ev;
  logic                 loop_ev;
  logic [STS_W-1:0]     set_w, sts_w, en_w;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    rbi_port_mon #(.STATE_W(STATE_W), .TMO_W(TMO_W)) u_mon (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bcn_i    (bcn_rx_i[g]),
      .state_i  (bcn_state_i[g*STATE_W +: STATE_W]),
      .period_i (tmo_period_i),
      .rx_o     (rx_ev[g]),
      .chg_o    (chg_ev[g]),
      .tmo_o    (tmo_ev[g])
    );
  end

  rbi_loop_det #(.MAC_W(MAC_W)) u_loop (
    .frame_i    (frame_rx_i),
    .sa_i       (frame_sa_i),
    .host_mac_i (host_mac_i),
    .loop_o     (loop_ev)
  );

  assign set_w = {loop_ev, tmo_ev, chg_ev, rx_ev};

  rbi_status_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_w),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .sts_o   (sts_w),
    .en_o    (en_w),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/rbi_irq_chk.sv
module rbi_irq_chk
  import rbi_pkg::*;
#(
  parameter int MAC_W = 48
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PORTS-1:0] bcn_rx_i,
  input logic                 frame_rx_i,
  input logic [MAC_W-1:0]     frame_sa_i,
  input logic [MAC_W-1:0]     host_mac_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [STS_W-1:0]     sts_i,
  input logic [STS_W-1:0]     en_i,
  input logic                 irq_o
);
  // R1, R8: a beacon always lands in status, even against a clear
  a_r1_rx_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcn_rx_i[0] |=> sts_i[B_RX]);

  a_r6_loop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_rx_i && frame_sa_i == host_mac_i) |=> sts_i[B_LOOP]);

  a_r7_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[B_LOOP] && !(reg_we_i && reg_addr_i == RA_STATUS && reg_wdata_i[B_LOOP]))
      |=> sts_i[B_LOOP]);

  a_r9_irq_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_i & en_i) != '0) |=> irq_o);

  a_r9_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_i & en_i) == '0) |=> !irq_o);
endmodule

bind ring_beacon_irq rbi_irq_chk #(.MAC_W(MAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bcn_rx_i    (bcn_rx_i),
  .frame_rx_i  (frame_rx_i),
  .frame_sa_i  (frame_sa_i),
  .host_mac_i  (host_mac_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sts_i       (sts_w),
  .en_i        (en_w),
  .irq_o       (irq_o)
);

// File: tb/ring_beacon_irq_bench.sv
`timescale 1ns/100ps
module ring_beacon_irq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  bcn_rx_i = '0;
  logic [15:0] bcn_state_i = '0;
  logic        frame_rx_i = 1'b0;
  logic [47:0] frame_sa_i = '0;
  logic [47:0] host_mac_i = 48'h02_11_22_33_44_55;
  logic [23:0] tmo_period_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        irq_o;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  ring_beacon_irq u_ring_beacon_irq (.*);

  // {port, expected change, state}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b0, 8'd3}, {1'b0, 1'b0, 8'd3}, {1'b0, 1'b1, 8'd5}, {1'b1, 1'b0, 8'd5},
    {1'b0, 1'b0, 8'd5}, {1'b1, 1'b1, 8'd9}, {1'b1, 1'b0, 8'd9}, {1'b0, 1'b1, 8'd3}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic beacon(int p, logic [7:0] st);
    @(negedge clk_i);
    bcn_rx_i[p] = 1'b1; bcn_state_i[p*8 +: 8] = st;
    @(negedge clk_i);
    bcn_rx_i = '0;
  endtask

  task automatic frame(logic [47:0] sa);
    @(negedge clk_i);
    frame_rx_i = 1'b1; frame_sa_i = sa;
    @(negedge clk_i);
    frame_rx_i = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(2'd0, d); chk("R10 reset status", d, 0);
    rd(2'd1, d); chk("R10 reset mask", d, 0);
    chk("R10 reset irq", irq_o, 0);

    foreach (VEC[i]) begin
      wr(2'd0, 8'h7F);
      beacon(int'(VEC[i][9]), VEC[i][7:0]);
      rd(2'd0, d);
      chk($sformatf("R1 vec %0d rx", i), d[VEC[i][9]], 1);
      chk($sformatf("R2/R3 vec %0d chg", i), d[2 + VEC[i][9]], VEC[i][8]);
    end

    // R4 timeout
    wr(2'd0, 8'h7F);
    @(negedge clk_i);
    tmo_period_i = 24'd5; bcn_rx_i = 2'b11;
    @(negedge clk_i);
    bcn_rx_i = '0;
    repeat (4) @(negedge clk_i);
    rd(2'd0, d); chk("R4 before expiry", d[5:4], 0);
    @(negedge clk_i);
    rd(2'd0, d); chk("R4 at expiry", d[5:4], 2'b11);
    wr(2'd0, 8'h7F);
    repeat (12) @(negedge clk_i);
    rd(2'd0, d); chk("R4 fires once", d[5:4], 0);

    // R3 after timeout: port 1 last state was 3
    beacon(0, 8'd7);
    rd(2'd0, d); chk("R3 first after timeout", d[2], 0);
    tmo_period_i = '0;
    wr(2'd0, 8'h7F);
    repeat (20) @(negedge clk_i);
    rd(2'd0, d); chk("R5 disabled", d[5:4], 0);

    // R6 loop
    frame(48'h02_11_22_33_44_56);
    rd(2'd0, d); chk("R6 other sa", d[6], 0);
    frame(host_mac_i);
    rd(2'd0, d); chk("R6 own sa", d[6], 1);

    // R7 write-one-to-clear
    beacon(1, 8'd9);
    rd(2'd0, d); chk("R7 setup", d, 8'h42);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R7 write zero", d, 8'h42);
    wr(2'd0, 8'h40);
    rd(2'd0, d); chk("R7 clear one", d, 8'h02);

    // R8 set beats clear
    @(negedge clk_i);
    bcn_rx_i[0] = 1'b1; bcn_state_i[7:0] = 8'd7;
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h01;
    @(negedge clk_i);
    bcn_rx_i = '0; reg_we_i = 1'b0;
    rd(2'd0, d); chk("R8 set wins", d[0], 1);

    // R9 masking
    @(negedge clk_i);
    chk("R9 masked off", irq_o, 0);
    wr(2'd1, 8'h01);
    @(negedge clk_i);
    chk("R9 enabled", irq_o, 1);
    wr(2'd0, 8'h01);
    @(negedge clk_i);
    chk("R9 still other bit", irq_o, 0);
    wr(2'd0, 8'h7F);
    wr(2'd2, 8'h01);
    frame(host_mac_i);
    @(negedge clk_i);
    chk("R9 loop enable", irq_o, 1);
    wr(2'd0, 8'h40);
    @(negedge clk_i);
    chk("R9 cleared", irq_o, 0);

    rd(2'd1, d); chk("R10 mask readback", d, 8'h01);
    rd(2'd2, d); chk("R10 ctrl readback", d, 8'h01);
    rd(2'd3, d); chk("R10 unused", d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule